// File: doc/BRIEF.md
# Morse Code LED Sequencer

The sequencer takes uppercase letters one at a time over a valid/ready handshake and blinks a single LED with the matching Morse pattern. Timing is built from a programmable unit length, given in clock cycles and sampled when each token is accepted. A token is either a letter byte, whose pattern comes from an internal table that covers A to Z, or a word-break token that plays a silent pause.

Gaps are built additively. Every element is followed by one dark unit. The last element of a letter is followed by two more dark units. A word break adds four dark units of its own. While a letter or a pause is playing, the block holds off new input and raises a busy flag. Bytes outside the letter range are consumed and dropped without stalling the sender.

Top module: `morse_led_seq`

## Requirements
- R1: After a synchronous active-high reset, `ledOn` is 0, `busy` is 0 and `inReady` is 1.
- R2: When a letter is accepted (`inValid` and `inReady` high at a clock edge, `inWordGap` 0), `ledOn` rises in the following cycle. A dot keeps it high for exactly U cycles and a dash for exactly 3U cycles, where U is the sampled unit length.
- R3: Every element, dot or dash, is followed by exactly U cycles with `ledOn` low.
- R4: After the dark unit that follows the last element of a letter, 2U further dark cycles follow, so that gap totals 3U. In the next cycle the block is idle again.
- R5: A token accepted with `inWordGap` = 1 plays 4U cycles with `ledOn` low and `busy` high. Its `inChar` byte is ignored.
- R6: A letter is a byte from 0x41 to 0x5A, and its table index is the byte minus 0x41. The table gives the standard international Morse pattern for each of the 26 letters, each 1 to 4 elements long, played first element first (for example A dot-dash, B dash-dot-dot-dot, Q dash-dash-dot-dash, Z dash-dash-dot-dot).
- R7: U is taken from `unitCycles` at the acceptance edge. Later changes to `unitCycles` do not affect a token that is already playing.
- R8: A byte outside 0x41 to 0x5A sent with `inWordGap` = 0 is consumed and dropped. `ledOn` stays low, `busy` stays low and `inReady` stays high.
- R9: From the cycle after a letter or word-break token is accepted until its last dark cycle, `inReady` is 0 and `busy` is 1.
- R10: A `unitCycles` value of 0 is treated as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inChar | input | 8 | Character byte offered |
| inWordGap | input | 1 | Token is a word break instead of a letter |
| inValid | input | 1 | Token offered |
| inReady | output | 1 | Token can be accepted this cycle |
| unitCycles | input | 24 | Unit length in clock cycles |
| ledOn | output | 1 | LED drive, 1 = lit |
| busy | output | 1 | A letter or pause is playing |

## Verification
The bench builds the block with its default widths: a 24-bit unit and patterns of up to four elements. It drives unit lengths of 0 to 3 cycles and a few larger ones. With units this short, every one of the 26 letters can be played and compared cycle by cycle against a light/dark trace that the bench derives from its own pattern strings. The bench changes `unitCycles` in the middle of letters and pauses and sweeps bytes on both sides of the letter range. This covers the sampling rule, the zero-unit clamp and the edges of the letter range.

// File: rtl/morse_pkg.sv
package morse_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_ON,
    S_OFF,
    S_CGAP,
    S_WGAP
  } seqState_t;

  typedef struct packed {
    logic       accept;
    logic       startOn;
    logic       startGap;
    logic [2:0] gapUnits;
  } seqStrobes_t;
endpackage

// File: rtl/morse_rom.sv
module morse_rom #(
  parameter int CHAR_W    = 8,
  parameter int MAX_ELEMS = 4,
  localparam int LEN_W    = $clog2(MAX_ELEMS + 1)
) (
  input  logic [CHAR_W-1:0]    inChar,
  output logic                 isLetter,
  output logic [LEN_W-1:0]     patLen,
  output logic [MAX_ELEMS-1:0] patMask
);
  localparam logic [CHAR_W-1:0] FIRST = CHAR_W'(8'h41);
  localparam logic [CHAR_W-1:0] LAST  = CHAR_W'(8'h5A);

  logic [CHAR_W-1:0] idx;
  assign idx      = inChar - FIRST;
  assign isLetter = (inChar >= FIRST) && (inChar <= LAST);

  // mask: 1 = dash, first element sits at bit patLen-1
  always_comb begin
    patLen  = '0;
    patMask = '0;
    case (idx)
      0:  begin patLen = 2; patMask = 4'b0001; end
      1:  begin patLen = 4; patMask = 4'b1000; end
      2:  begin patLen = 4; patMask = 4'b1010; end
      3:  begin patLen = 3; patMask = 4'b0100; end
      4:  begin patLen = 1; patMask = 4'b0000; end
      5:  begin patLen = 4; patMask = 4'b0010; end
      6:  begin patLen = 3; patMask = 4'b0110; end
      7:  begin patLen = 4; patMask = 4'b0000; end
      8:  begin patLen = 2; patMask = 4'b0000; end
      9:  begin patLen = 4; patMask = 4'b0111; end
      10: begin patLen = 3; patMask = 4'b0101; end
      11: begin patLen = 4; patMask = 4'b0100; end
      12: begin patLen = 2; patMask = 4'b0011; end
      13: begin patLen = 2; patMask = 4'b0010; end
      14: begin patLen = 3; patMask = 4'b0111; end
      15: begin patLen = 4; patMask = 4'b0110; end
      16: begin patLen = 4; patMask = 4'b1101; end
      17: begin patLen = 3; patMask = 4'b0010; end
      18: begin patLen = 3; patMask = 4'b0000; end
      19: begin patLen = 1; patMask = 4'b0001; end
      20: begin patLen = 3; patMask = 4'b0001; end
      21: begin patLen = 4; patMask = 4'b0001; end
      22: begin patLen = 3; patMask = 4'b0011; end
      23: begin patLen = 4; patMask = 4'b1001; end
      24: begin patLen = 4; patMask = 4'b1011; end
      25: begin patLen = 4; patMask = 4'b1100; end
      default: begin patLen = '0; patMask = '0; end
    endcase
  end
endmodule

// File: rtl/morse_ctrl.sv
module morse_ctrl
  import morse_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        inValid,
  input  logic        inWordGap,
  input  logic        isLetter,
  input  logic        cntDone,
  input  logic        moreElems,
  output seqStrobes_t strobes,
  output logic        inReady,
  output logic        busy
);
  seqState_t state, nextState;

  always_comb begin
    nextState = state;
    strobes   = '0;
    case (state)
      S_IDLE: begin
        if (inValid && inWordGap) begin
          strobes.accept   = 1'b1;
          strobes.startGap = 1'b1;
          strobes.gapUnits = 3'd4;
          nextState        = S_WGAP;
        end else if (inValid && isLetter) begin
          strobes.accept  = 1'b1;
          strobes.startOn = 1'b1;
          nextState       = S_ON;
        end
      end
      S_ON: if (cntDone) begin
        strobes.startGap = 1'b1;
        strobes.gapUnits = 3'd1;
        nextState        = S_OFF;
      end
      S_OFF: if (cntDone) begin
        if (moreElems) begin
          strobes.startOn = 1'b1;
          nextState       = S_ON;
        end else begin
          strobes.startGap = 1'b1;
          strobes.gapUnits = 3'd2;
          nextState        = S_CGAP;
        end
      end
      S_CGAP, S_WGAP: if (cntDone) nextState = S_IDLE;
      default: nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= S_IDLE;
    else     state <= nextState;
  end

  assign inReady = (state == S_IDLE);
  assign busy    = (state != S_IDLE);

  AST_IGNORE_JUNK: assert property (@(posedge clk) disable iff (rst)
    (state == S_IDLE && inValid && !isLetter && !inWordGap) |=> (state == S_IDLE)); // R8
endmodule

// File: rtl/morse_dp.sv
module morse_dp
  import morse_pkg::*;
#(
  parameter int UNIT_W    = 24,
  parameter int MAX_ELEMS = 4,
  localparam int LEN_W    = $clog2(MAX_ELEMS + 1),
  localparam int CNT_W    = UNIT_W + 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  seqStrobes_t          strobes,
  input  logic [UNIT_W-1:0]    unitIn,
  input  logic [LEN_W-1:0]     romLen,
  input  logic [MAX_ELEMS-1:0] romMask,
  output logic                 ledOn,
  output logic                 cntDone,
  output logic                 moreElems
);
  logic [UNIT_W-1:0]    unitReg, unitEff, unitSel;
  logic [MAX_ELEMS-1:0] shReg, aligned;
  logic [LEN_W-1:0]     elemLeft;
  logic [CNT_W-1:0]     cnt, onLoad, gapLoad;
  logic                 dashSel;

  assign unitEff = (unitIn == '0) ? UNIT_W'(1) : unitIn;
  assign unitSel = strobes.accept ? unitEff : unitReg;
  assign aligned = romMask << (LEN_W'(MAX_ELEMS) - romLen);
  assign dashSel = strobes.accept ? aligned[MAX_ELEMS-1] : shReg[MAX_ELEMS-2];

  assign onLoad = dashSel ? (CNT_W'(unitSel) + (CNT_W'(unitSel) << 1)) : CNT_W'(unitSel);

  always_comb begin
    case (strobes.gapUnits)
      3'd2:    gapLoad = CNT_W'(unitSel) << 1;
      3'd4:    gapLoad = CNT_W'(unitSel) << 2;
      default: gapLoad = CNT_W'(unitSel);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      unitReg  <= '0;
      shReg    <= '0;
      elemLeft <= '0;
      cnt      <= '0;
      ledOn    <= 1'b0;
    end else begin
      if (strobes.accept) unitReg <= unitEff;
      if (strobes.startOn) begin
        ledOn <= 1'b1;
        cnt   <= onLoad;
        if (strobes.accept) begin
          shReg    <= aligned;
          elemLeft <= romLen - LEN_W'(1);
        end else begin
          shReg    <= shReg << 1;
          elemLeft <= elemLeft - LEN_W'(1);
        end
      end else if (strobes.startGap) begin
        ledOn <= 1'b0;
        cnt   <= gapLoad;
      end else if (cnt != '0) begin
        cnt <= cnt - CNT_W'(1);
      end
    end
  end

  assign cntDone   = (cnt == CNT_W'(1));
  assign moreElems = (elemLeft != '0);

  AST_LIT_TIMED: assert property (@(posedge clk) disable iff (rst)
    ledOn |-> (cnt != '0)); // R2
endmodule

// File: rtl/morse_led_seq.sv
module morse_led_seq
  import morse_pkg::*;
#(
  parameter int CHAR_W    = 8,
  parameter int UNIT_W    = 24,
  parameter int MAX_ELEMS = 4,
  localparam int LEN_W    = $clog2(MAX_ELEMS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CHAR_W-1:0] inChar,
  input  logic              inWordGap,
  input  logic              inValid,
  output logic              inReady,
  input  logic [UNIT_W-1:0] unitCycles,
  output logic              ledOn,
  output logic              busy
);
  seqStrobes_t          strobes;
  logic                 isLetter, cntDone, moreElems;
  logic [LEN_W-1:0]     romLen;
  logic [MAX_ELEMS-1:0] romMask;

  morse_rom #(.CHAR_W(CHAR_W), .MAX_ELEMS(MAX_ELEMS)) uRom (
    .inChar(inChar), .isLetter(isLetter), .patLen(romLen), .patMask(romMask)
  );

  morse_ctrl uCtrl (
    .clk(clk), .rst(rst), .inValid(inValid), .inWordGap(inWordGap),
    .isLetter(isLetter), .cntDone(cntDone), .moreElems(moreElems),
    .strobes(strobes), .inReady(inReady), .busy(busy)
  );

  morse_dp #(.UNIT_W(UNIT_W), .MAX_ELEMS(MAX_ELEMS)) uDp (
    .clk(clk), .rst(rst), .strobes(strobes), .unitIn(unitCycles),
    .romLen(romLen), .romMask(romMask), .ledOn(ledOn),
    .cntDone(cntDone), .moreElems(moreElems)
  );

  AST_LETTER_LIGHTS: assert property (@(posedge clk) disable iff (rst)
    (inValid && inReady && !inWordGap && isLetter) |=> ledOn); // R2
  AST_WORD_DARK: assert property (@(posedge clk) disable iff (rst)
    (inValid && inReady && inWordGap) |=> (busy && !ledOn)); // R5
  AST_END_DARK: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> !ledOn); // R4
  AST_HOLD_OFF: assert property (@(posedge clk) disable iff (rst)
    (inValid && inReady && (inWordGap || isLetter)) |=> !inReady); // R9
endmodule

// File: tb/morse_led_seq_test.sv
module morse_led_seq_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic [7:0]  inChar;
  logic        inWordGap;
  logic        inValid;
  logic        inReady;
  logic [23:0] unitCycles;
  logic        ledOn;
  logic        busy;

  int vectors = 0;
  int fails   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  morse_led_seq uut (
    .clk(clk), .rst(rst), .inChar(inChar), .inWordGap(inWordGap),
    .inValid(inValid), .inReady(inReady), .unitCycles(unitCycles),
    .ledOn(ledOn), .busy(busy)
  );

  task automatic chk(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s t=%0t actual=%0d expected=%0d", tag, $time, act, exp);
    end
  endtask

  function automatic string patOf(input int i);
    string t[26] = '{".-", "-...", "-.-.", "-..", ".", "..-.", "--.", "....",
                     "..", ".---", "-.-", ".-..", "--", "-.", "---", ".--.",
                     "--.-", ".-.", "...", "-", "..-", "...-", ".--", "-..-",
                     "-.--", "--.."};
    return t[i];
  endfunction

  // Offer one token at a negedge; after acceptance, scramble the unit input
  task automatic offer(input logic [7:0] ch, input logic wg, input int unit);
    chk("R9 ready before offer", inReady, 1);
    inChar = ch; inWordGap = wg; inValid = 1'b1; unitCycles = 24'(unit);
    @(negedge clk);
    inValid = 1'b0; unitCycles = 24'(unit + 7); // R7: late change ignored
  endtask

  task automatic playLetter(input int li, input int unit);
    string p;
    bit    expQ[$];
    int    u;
    u = (unit == 0) ? 1 : unit; // R10
    p = patOf(li);
    for (int e = 0; e < p.len(); e++) begin
      int on;
      on = (p[e] == "-") ? 3 * u : u;
      for (int k = 0; k < on; k++) expQ.push_back(1'b1); // R2
      for (int k = 0; k < u; k++) expQ.push_back(1'b0);  // R3
    end
    for (int k = 0; k < 2 * u; k++) expQ.push_back(1'b0); // R4
    offer(8'(8'h41 + li), 1'b0, unit);
    foreach (expQ[k]) begin
      chk("R6 letter trace", ledOn, expQ[k]);
      chk("R9 busy", busy, 1);
      chk("R9 ready low", inReady, 0);
      @(negedge clk);
    end
    chk("R4 idle after letter", busy, 0);
    chk("R4 led dark after letter", ledOn, 0);
  endtask

  task automatic playWord(input logic [7:0] ch, input int unit);
    int u;
    u = (unit == 0) ? 1 : unit;
    offer(ch, 1'b1, unit);
    for (int k = 0; k < 4 * u; k++) begin
      chk("R5 word dark", ledOn, 0);
      chk("R5 word busy", busy, 1);
      @(negedge clk);
    end
    chk("R5 idle after word", busy, 0);
  endtask

  task automatic junk(input logic [7:0] ch);
    offer(ch, 1'b0, 2);
    for (int k = 0; k < 3; k++) begin
      chk("R8 junk led", ledOn, 0);
      chk("R8 junk busy", busy, 0);
      chk("R8 junk ready", inReady, 1);
      @(negedge clk);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    rst = 1'b1; inChar = 8'h0; inWordGap = 1'b0; inValid = 1'b0; unitCycles = 24'd1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 reset led", ledOn, 0);
    chk("R1 reset busy", busy, 0);
    chk("R1 reset ready", inReady, 1);

    for (int u = 1; u <= 3; u++)
      for (int li = 0; li < 26; li++) playLetter(li, u);
    for (int li = 0; li < 26; li += 5) playLetter(li, 0); // R10
    playLetter(16, 6);
    playWord(8'h45, 2);  // R5: letter byte with word flag ignored
    playWord(8'h00, 5);
    playWord(8'h51, 0);
    junk(8'h40); junk(8'h5B); junk(8'h61); junk(8'h30); junk(8'hFF);
    playLetter(0, 1);    // still works after junk

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule